// File: doc/BRIEF.md
# Interrupt Source Routing Dispatcher

This block takes a trigger for one logical interrupt source and carries it through a two-level routing walk. First it fetches the source's routing entry and checks it. Then it fetches the event queue descriptor that the entry names. If the descriptor enables enqueueing, it asks for the entry's event data to be pushed into that queue. Finally it finds the target thread and the priority in the descriptor and sets the matching bit in that thread's pending-priority byte.

Both tables, the queue writer and the pending-byte store are outside the block. The block reaches each of them through a request/acknowledge port. Only one trigger is in flight at a time. Each trigger ends with a one-cycle completion pulse that carries a status code.

Top module: `irq_route_dispatch`

## Requirements
- R1: After reset `trig_ready` is 1 and no request, write or completion output is active. A trigger is taken on a cycle where `trig_valid` and `trig_ready` are both 1. `trig_ready` then stays 0 until the cycle after that trigger's `done_o` pulse.
- R2: For each accepted trigger, `src_req` rises with `src_idx` equal to the trigger's source number. Both are held until `src_ack`.
- R3: The source entry is laid out as follows: bit ENT_W-1 is valid, bit ENT_W-2 is masked, the next DESC_W bits are the descriptor index, and the low EDATA_W bits are the event data. If `src_found` is 0 or the valid bit is 0, the trigger ends with status 4. No descriptor lookup, push or pending write takes place.
- R4: A valid entry with its masked bit set ends with status 1 and `err_o` at 0. No descriptor lookup, push or pending write takes place.
- R5: Otherwise `desc_req` is raised with `desc_idx` equal to the entry's descriptor index. If `desc_found` is 0, the trigger ends with status 5 and there is no push or write.
- R6: If bit 31 of `desc_w0` is 1, `push_req` is raised with `push_queue` equal to the descriptor index and `push_data` equal to the event data. Both are held until `push_ack`, and exactly one push is made. If that bit is 0, no push is made.
- R7: After the push step, three checks run in this order: target, then format, then priority. The target thread is `desc_w6[THR_W-1:0]`. A value of NUM_THREADS or above means there is no target, and the trigger ends with status 6 and no pending write.
- R8: If bit 31 of `desc_w6` is 1, the trigger ends with status 3 (unsupported format), `err_o` is 0, and there is no pending write.
- R9: The priority is `desc_w7[7:0]`. A value of 0xFF (queue masked), or any value above 7, ends the trigger with status 2 and no pending write.
- R10: A priority p from 0 to 7 causes exactly one write cycle with `pend_thread` set to the target. `pend_wdata` equals `pend_rdata` OR (0x80 >> p), so bits already set are kept. The status is 0.
- R11: Every accepted trigger gives exactly one one-cycle `done_o` pulse, with `status_o` valid in that cycle. `err_o` is 1 exactly when `done_o` is 1 and status bit 2 is 1 (status 4, 5 or 6).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger present |
| trig_src | input | SRC_W | Logical source number of the trigger |
| trig_ready | output | 1 | Block idle, trigger can be taken |
| src_req | output | 1 | Routing-entry lookup request |
| src_idx | output | SRC_W | Source number being looked up |
| src_ack | input | 1 | Routing-entry response valid |
| src_found | input | 1 | An entry exists for the source |
| src_entry | input | ENT_W | Routing entry contents |
| desc_req | output | 1 | Queue-descriptor lookup request |
| desc_idx | output | DESC_W | Descriptor index being looked up |
| desc_ack | input | 1 | Descriptor response valid |
| desc_found | input | 1 | A descriptor exists at the index |
| desc_w0 | input | 32 | Descriptor word 0 (bit 31 enqueue enable) |
| desc_w6 | input | 32 | Descriptor word 6 (bit 31 format, low bits target) |
| desc_w7 | input | 32 | Descriptor word 7 (bits 7:0 priority) |
| push_req | output | 1 | Queue push request |
| push_queue | output | DESC_W | Queue receiving the push |
| push_data | output | EDATA_W | Event data to push |
| push_ack | input | 1 | Push accepted |
| pend_we | output | 1 | Pending-byte write strobe |
| pend_thread | output | THR_W | Thread whose pending byte is read and written |
| pend_rdata | input | 8 | Current pending byte of `pend_thread` |
| pend_wdata | output | 8 | New pending byte |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 3 | Completion status code |
| err_o | output | 1 | Completion with an error status |

## Verification
The bench keeps the defaults: a 12-bit source number, a 10-bit descriptor index, 31 bits of event data, and a 6-bit thread field with NUM_THREADS at 48. Because the field can encode 64 threads but only 48 exist, random descriptors often name threads 48 to 63, so the missing-target path comes up often. Thread 47 against 48 is also tried directly. All 64 pending bytes start random, so each pending write is checked for keeping the bits already set. Lookup and push acknowledges arrive after random delays, which exercises the request-hold behaviour.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;

  localparam int WORD_W = 32;
  localparam int PRIO_W = 8;
  localparam int PEND_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_SRC, S_DESC, S_PUSH, S_RES, S_PEND, S_DONE
  } disp_state_t;

  // bit 2 set marks an error outcome
  typedef enum logic [2:0] {
    ST_OK         = 3'd0,
    ST_SRC_MASKED = 3'd1,
    ST_NO_PRIO    = 3'd2,
    ST_FMT_UNSUP  = 3'd3,
    ST_BAD_SRC    = 3'd4,
    ST_NO_DESC    = 3'd5,
    ST_NO_TARGET  = 3'd6
  } disp_status_t;

endpackage

// File: rtl/irq_route_fields.sv
module irq_route_fields
  import irq_route_pkg::*;
#(
  parameter int DESC_W  = 10,
  parameter int EDATA_W = 31,
  parameter int THR_W   = 6,
  localparam int ENT_W  = 2 + DESC_W + EDATA_W
) (
  input  logic [ENT_W-1:0]   src_entry,
  input  logic [WORD_W-1:0]  desc_w0,
  input  logic [WORD_W-1:0]  desc_w6,
  input  logic [WORD_W-1:0]  desc_w7,
  output logic               f_valid,
  output logic               f_masked,
  output logic [DESC_W-1:0]  f_qidx,
  output logic [EDATA_W-1:0] f_data,
  output logic               f_enq,
  output logic               f_fmt,
  output logic [THR_W-1:0]   f_thread,
  output logic [PRIO_W-1:0]  f_prio
);

  assign f_valid  = src_entry[ENT_W-1];
  assign f_masked = src_entry[ENT_W-2];
  assign f_qidx   = src_entry[EDATA_W +: DESC_W];
  assign f_data   = src_entry[EDATA_W-1:0];

  assign f_enq    = desc_w0[WORD_W-1];
  assign f_fmt    = desc_w6[WORD_W-1];
  assign f_thread = desc_w6[THR_W-1:0];
  assign f_prio   = desc_w7[PRIO_W-1:0];

  logic unused_desc_bits;
  assign unused_desc_bits = ^{desc_w0[WORD_W-2:0], desc_w6[WORD_W-2:THR_W],
                              desc_w7[WORD_W-1:PRIO_W]};

endmodule

// File: rtl/irq_prio_mask.sv
module irq_prio_mask
  import irq_route_pkg::*;
(
  input  logic [PRIO_W-1:0] prio,
  output logic              in_range,
  output logic [PEND_W-1:0] mask
);

  assign in_range = (prio < PRIO_W'(PEND_W));

  // priority 0 lands on the most significant bit
  for (genvar g = 0; g < PEND_W; g++) begin : g_bit
    assign mask[g] = (prio == PRIO_W'(PEND_W - 1 - g));
  end

endmodule

// File: rtl/irq_route_fsm.sv
module irq_route_fsm
  import irq_route_pkg::*;
#(
  parameter int SRC_W       = 12,
  parameter int DESC_W      = 10,
  parameter int EDATA_W     = 31,
  parameter int THR_W       = 6,
  parameter int NUM_THREADS = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [SRC_W-1:0]   trig_src,
  output logic               trig_ready,
  output logic               src_req,
  output logic [SRC_W-1:0]   src_idx,
  input  logic               src_ack,
  input  logic               src_found,
  input  logic               f_valid,
  input  logic               f_masked,
  input  logic [DESC_W-1:0]  f_qidx,
  input  logic [EDATA_W-1:0] f_data,
  output logic               desc_req,
  input  logic               desc_ack,
  input  logic               desc_found,
  input  logic               f_enq,
  input  logic               f_fmt,
  input  logic [THR_W-1:0]   f_thread,
  input  logic [PRIO_W-1:0]  f_prio,
  output logic [DESC_W-1:0]  qidx_q,
  output logic [EDATA_W-1:0] data_q,
  output logic               push_req,
  input  logic               push_ack,
  input  logic               prio_ok,
  output logic [THR_W-1:0]   thr_q,
  output logic [PRIO_W-1:0]  prio_q,
  output logic               pend_we,
  output logic               done_o,
  output logic [2:0]         status_o,
  output logic               err_o
);

  localparam logic [THR_W:0] THR_LIM = (THR_W+1)'(NUM_THREADS);

  disp_state_t  state_q, state_d;
  disp_status_t status_q, status_d;
  logic         fmt_q;
  logic         src_en, ent_en, desc_en;
  logic [SRC_W-1:0] src_q;

  // next-state process
  always_comb begin
    state_d  = state_q;
    status_d = status_q;
    src_en   = 1'b0;
    ent_en   = 1'b0;
    desc_en  = 1'b0;
    unique case (state_q)
      S_IDLE: if (trig_valid) begin
        state_d = S_SRC;
        src_en  = 1'b1;
      end
      S_SRC: if (src_ack) begin
        if (!src_found || !f_valid) begin
          state_d = S_DONE; status_d = ST_BAD_SRC;
        end else if (f_masked) begin
          state_d = S_DONE; status_d = ST_SRC_MASKED;
        end else begin
          state_d = S_DESC; ent_en = 1'b1;
        end
      end
      S_DESC: if (desc_ack) begin
        if (!desc_found) begin
          state_d = S_DONE; status_d = ST_NO_DESC;
        end else begin
          desc_en = 1'b1;
          state_d = f_enq ? S_PUSH : S_RES;
        end
      end
      S_PUSH: if (push_ack) state_d = S_RES;
      S_RES: begin
        state_d = S_DONE;
        if ({1'b0, thr_q} >= THR_LIM) status_d = ST_NO_TARGET;
        else if (fmt_q)               status_d = ST_FMT_UNSUP;
        else if (!prio_ok)            status_d = ST_NO_PRIO;
        else begin
          state_d = S_PEND; status_d = ST_OK;
        end
      end
      S_PEND: state_d = S_DONE;
      S_DONE: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      src_q    <= '0;
      qidx_q   <= '0;
      data_q   <= '0;
      thr_q    <= '0;
      prio_q   <= '0;
      fmt_q    <= 1'b0;
    end else begin
      state_q  <= state_d;
      status_q <= status_d;
      if (src_en) src_q <= trig_src;
      if (ent_en) begin
        qidx_q <= f_qidx;
        data_q <= f_data;
      end
      if (desc_en) begin
        thr_q  <= f_thread;
        prio_q <= f_prio;
        fmt_q  <= f_fmt;
      end
    end
  end

  assign trig_ready = (state_q == S_IDLE);
  assign src_req    = (state_q == S_SRC);
  assign src_idx    = src_q;
  assign desc_req   = (state_q == S_DESC);
  assign push_req   = (state_q == S_PUSH);
  assign pend_we    = (state_q == S_PEND);
  assign done_o     = (state_q == S_DONE);
  assign status_o   = status_q;
  assign err_o      = done_o & status_q[2];

  p_one_at_a_time_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid && trig_ready |=> !trig_ready);

  p_src_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    src_req && !src_ack |=> src_req && $stable(src_idx));

  p_push_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push_req && !push_ack |=> push_req && $stable(data_q) && $stable(qidx_q));

  p_write_then_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we |=> done_o && !err_o && status_o == 3'd0);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o && trig_ready);

  p_err_in_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> done_o);

endmodule

// File: rtl/irq_route_dispatch.sv
module irq_route_dispatch
  import irq_route_pkg::*;
#(
  parameter int SRC_W       = 12,
  parameter int DESC_W      = 10,
  parameter int EDATA_W     = 31,
  parameter int THR_W       = 6,
  parameter int NUM_THREADS = 48,
  localparam int ENT_W      = 2 + DESC_W + EDATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trig_valid,
  input  logic [SRC_W-1:0]   trig_src,
  output logic               trig_ready,
  output logic               src_req,
  output logic [SRC_W-1:0]   src_idx,
  input  logic               src_ack,
  input  logic               src_found,
  input  logic [ENT_W-1:0]   src_entry,
  output logic               desc_req,
  output logic [DESC_W-1:0]  desc_idx,
  input  logic               desc_ack,
  input  logic               desc_found,
  input  logic [31:0]        desc_w0,
  input  logic [31:0]        desc_w6,
  input  logic [31:0]        desc_w7,
  output logic               push_req,
  output logic [DESC_W-1:0]  push_queue,
  output logic [EDATA_W-1:0] push_data,
  input  logic               push_ack,
  output logic               pend_we,
  output logic [THR_W-1:0]   pend_thread,
  input  logic [7:0]         pend_rdata,
  output logic [7:0]         pend_wdata,
  output logic               done_o,
  output logic [2:0]         status_o,
  output logic               err_o
);

  logic               f_valid, f_masked, f_enq, f_fmt, prio_ok;
  logic [DESC_W-1:0]  f_qidx, qidx_q;
  logic [EDATA_W-1:0] f_data, data_q;
  logic [THR_W-1:0]   f_thread, thr_q;
  logic [PRIO_W-1:0]  f_prio, prio_q;
  logic [PEND_W-1:0]  prio_bit;

  irq_route_fields #(.DESC_W(DESC_W), .EDATA_W(EDATA_W), .THR_W(THR_W)) u_fields (
    .src_entry(src_entry), .desc_w0(desc_w0), .desc_w6(desc_w6), .desc_w7(desc_w7),
    .f_valid(f_valid), .f_masked(f_masked), .f_qidx(f_qidx), .f_data(f_data),
    .f_enq(f_enq), .f_fmt(f_fmt), .f_thread(f_thread), .f_prio(f_prio)
  );

  irq_route_fsm #(
    .SRC_W(SRC_W), .DESC_W(DESC_W), .EDATA_W(EDATA_W),
    .THR_W(THR_W), .NUM_THREADS(NUM_THREADS)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .trig_valid(trig_valid), .trig_src(trig_src), .trig_ready(trig_ready),
    .src_req(src_req), .src_idx(src_idx), .src_ack(src_ack), .src_found(src_found),
    .f_valid(f_valid), .f_masked(f_masked), .f_qidx(f_qidx), .f_data(f_data),
    .desc_req(desc_req), .desc_ack(desc_ack), .desc_found(desc_found),
    .f_enq(f_enq), .f_fmt(f_fmt), .f_thread(f_thread), .f_prio(f_prio),
    .qidx_q(qidx_q), .data_q(data_q),
    .push_req(push_req), .push_ack(push_ack),
    .prio_ok(prio_ok), .thr_q(thr_q), .prio_q(prio_q),
    .pend_we(pend_we), .done_o(done_o), .status_o(status_o), .err_o(err_o)
  );

  irq_prio_mask u_mask (
    .prio(prio_q), .in_range(prio_ok), .mask(prio_bit)
  );

  assign desc_idx    = qidx_q;
  assign push_queue  = qidx_q;
  assign push_data   = data_q;
  assign pend_thread = thr_q;
  assign pend_wdata  = pend_rdata | prio_bit;

  // the write may only add a single bit and must keep every set bit
  p_pend_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we |-> ((pend_wdata & pend_rdata) == pend_rdata)
                && $countones(pend_wdata & ~pend_rdata) <= 1);

endmodule

// File: tb/irq_route_dispatch_tb_top.sv
`timescale 1ns/1ps
module irq_route_dispatch_tb_top;

  localparam int SRC_W = 12, DESC_W = 10, EDATA_W = 31, THR_W = 6, NTHR = 48;
  localparam int ENT_W = 2 + DESC_W + EDATA_W;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic               trig_valid, trig_ready, src_req, src_ack, src_found;
  logic [SRC_W-1:0]   trig_src, src_idx;
  logic [ENT_W-1:0]   src_entry;
  logic               desc_req, desc_ack, desc_found, push_req, push_ack;
  logic [DESC_W-1:0]  desc_idx, push_queue;
  logic [31:0]        desc_w0, desc_w6, desc_w7;
  logic [EDATA_W-1:0] push_data;
  logic               pend_we, done_o, err_o;
  logic [THR_W-1:0]   pend_thread;
  logic [7:0]         pend_rdata, pend_wdata;
  logic [2:0]         status_o;

  logic [7:0] pend_mem [64];
  assign pend_rdata = pend_mem[pend_thread];

  irq_route_dispatch dut_i (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  int n_src, n_desc, n_push, n_pend;
  logic [SRC_W-1:0]   seen_src;
  logic [DESC_W-1:0]  seen_desc, seen_pq;
  logic [EDATA_W-1:0] seen_pd;
  logic [THR_W-1:0]   seen_thr;
  int sd = 0, dd = 0, pd = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // responders for the lookup, push and pending ports
  always @(negedge clk) begin
    if (src_ack) src_ack = 1'b0;
    else if (src_req) begin
      if (sd == 0) begin src_ack = 1'b1; n_src++; seen_src = src_idx; sd = $urandom % 3; end
      else sd--;
    end
    if (desc_ack) desc_ack = 1'b0;
    else if (desc_req) begin
      if (dd == 0) begin desc_ack = 1'b1; n_desc++; seen_desc = desc_idx; dd = $urandom % 3; end
      else dd--;
    end
    if (push_ack) push_ack = 1'b0;
    else if (push_req) begin
      if (pd == 0) begin
        push_ack = 1'b1; n_push++; seen_pq = push_queue; seen_pd = push_data; pd = $urandom % 4;
      end else pd--;
    end
    if (pend_we) begin
      n_pend++; seen_thr = pend_thread; pend_mem[pend_thread] = pend_wdata;
    end
  end

  function automatic logic [2:0] exp_status();
    if (!src_found || !src_entry[ENT_W-1]) return 3'd4;
    if (src_entry[ENT_W-2])                return 3'd1;
    if (!desc_found)                       return 3'd5;
    if (desc_w6[THR_W-1:0] >= THR_W'(NTHR)) return 3'd6;
    if (desc_w6[31])                       return 3'd3;
    if (desc_w7[7:0] > 8'd7)               return 3'd2;
    return 3'd0;
  endfunction

  function automatic string tag_of(input logic [2:0] s);
    case (s)
      3'd0: return "R10"; 3'd1: return "R4"; 3'd2: return "R9"; 3'd3: return "R8";
      3'd4: return "R3";  3'd5: return "R5"; default: return "R7";
    endcase
  endfunction

  function automatic logic [ENT_W-1:0] mk_ent(input bit v, input bit m, input logic [DESC_W-1:0] q,
                                              input logic [EDATA_W-1:0] d);
    return {v, m, q, d};
  endfunction

  task automatic run_one(input bit f, input logic [ENT_W-1:0] e, input bit df,
                         input logic [31:0] a0, input logic [31:0] a6, input logic [31:0] a7);
    logic [2:0] es;
    logic [7:0] old, expm;
    logic [THR_W-1:0] thr;
    logic [SRC_W-1:0] src;
    bit reach_desc, exp_push;
    int w;
    @(negedge clk);
    src_found = f; src_entry = e; desc_found = df;
    desc_w0 = a0; desc_w6 = a6; desc_w7 = a7;
    es = exp_status();
    thr = a6[THR_W-1:0];
    old = pend_mem[thr];
    reach_desc = f && e[ENT_W-1] && !e[ENT_W-2];
    exp_push = reach_desc && df && a0[31];
    n_src = 0; n_desc = 0; n_push = 0; n_pend = 0;
    chk(trig_ready == 1'b1, "R1 ready when idle", 64'(trig_ready), 64'd1);
    src = SRC_W'($urandom);
    trig_valid = 1'b1; trig_src = src;
    @(negedge clk);
    trig_valid = 1'b0; trig_src = ~src;
    chk(trig_ready == 1'b0, "R1 busy after accept", 64'(trig_ready), 64'd0);
    w = 0;
    while (!done_o && w < 200) begin @(negedge clk); w++; end
    if (!done_o) begin
      chk(1'b0, "R11 done timeout", 64'd0, 64'd1);
      return;
    end
    chk(status_o == es, tag_of(es), 64'(status_o), 64'(es));
    chk(err_o == es[2], "R11 err flag", 64'(err_o), 64'(es[2]));
    chk(n_src == 1 && seen_src == src, "R2 source lookup", 64'(seen_src), 64'(src));
    chk(n_desc == int'(reach_desc), "R5 descriptor lookups", 64'(n_desc), 64'(reach_desc));
    if (reach_desc)
      chk(seen_desc == e[EDATA_W +: DESC_W], "R5 descriptor index", 64'(seen_desc),
          64'(e[EDATA_W +: DESC_W]));
    chk(n_push == int'(exp_push), "R6 push count", 64'(n_push), 64'(exp_push));
    if (exp_push)
      chk(seen_pq == e[EDATA_W +: DESC_W] && seen_pd == e[EDATA_W-1:0], "R6 push content",
          64'({seen_pq, seen_pd}), 64'({e[EDATA_W +: DESC_W], e[EDATA_W-1:0]}));
    expm = (es == 3'd0) ? (old | (8'h80 >> a7[2:0])) : old;
    chk(n_pend == int'(es == 3'd0), "R10 write count", 64'(n_pend), 64'(es == 3'd0));
    chk(pend_mem[thr] == expm, "R10 pending byte", 64'(pend_mem[thr]), 64'(expm));
    if (es == 3'd0) chk(seen_thr == thr, "R10 write thread", 64'(seen_thr), 64'(thr));
    @(negedge clk);
    chk(trig_ready == 1'b1 && done_o == 1'b0, "R11 single pulse / R1 ready", 64'({trig_ready, done_o}), 64'b10);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; trig_valid = 1'b0; trig_src = '0;
    src_ack = 1'b0; desc_ack = 1'b0; push_ack = 1'b0;
    src_found = 1'b0; src_entry = '0; desc_found = 1'b0;
    desc_w0 = '0; desc_w6 = '0; desc_w7 = '0;
    for (int i = 0; i < 64; i++) pend_mem[i] = 8'($urandom);
    repeat (3) @(negedge clk);
    chk(trig_ready && !src_req && !desc_req && !push_req && !pend_we && !done_o && !err_o,
        "R1 reset state", 64'({trig_ready, src_req, desc_req, push_req, pend_we, done_o}), 64'b100000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // directed corner cases
    pend_mem[0] = 8'h00; pend_mem[5] = 8'h00; pend_mem[47] = 8'h5A;
    run_one(1, mk_ent(1, 0, 10'd3, 31'h1234), 1, 32'h8000_0000, 32'd0, 32'd0);   // R10 prio 0 -> 0x80
    run_one(1, mk_ent(1, 0, 10'd4, 31'h7fff_ffff), 1, 32'h0, 32'd5, 32'd7);      // R10 prio 7 -> 0x01, R6 no push
    run_one(1, mk_ent(1, 0, 10'd9, 31'h55), 1, 32'h8000_0000, 32'd47, 32'd2);    // R7 last valid thread
    run_one(1, mk_ent(1, 0, 10'd9, 31'h55), 1, 32'h8000_0000, 32'd48, 32'd2);    // R7 first missing thread
    run_one(1, mk_ent(1, 0, 10'd1, 31'h1), 1, 32'h0, 32'd2, 32'hFF);             // R9 queue masked
    run_one(1, mk_ent(1, 0, 10'd1, 31'h1), 1, 32'h0, 32'd2, 32'd8);              // R9 out of range
    run_one(1, mk_ent(1, 0, 10'd1, 31'h1), 1, 32'h8000_0000, 32'h8000_0002, 32'd1); // R8 format 1
    run_one(1, mk_ent(1, 1, 10'd1, 31'h1), 1, 32'h8000_0000, 32'd2, 32'd1);      // R4 masked source
    run_one(1, mk_ent(0, 0, 10'd1, 31'h1), 1, 32'h8000_0000, 32'd2, 32'd1);      // R3 invalid
    run_one(0, mk_ent(1, 0, 10'd1, 31'h1), 1, 32'h8000_0000, 32'd2, 32'd1);      // R3 missing
    run_one(1, mk_ent(1, 0, 10'd1, 31'h1), 0, 32'h8000_0000, 32'd2, 32'd1);      // R5 no descriptor

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a0, a6, a7;
      bit v, m, f, df;
      f  = ($urandom % 10) != 0;
      v  = ($urandom % 10) != 0;
      m  = ($urandom % 7) == 0;
      df = ($urandom % 10) != 0;
      a0 = $urandom;
      a6 = {($urandom % 7) == 0, 25'($urandom), 6'($urandom)};
      case ($urandom % 10)
        0:       a7 = {$urandom, 8'hFF} >> 0;
        1:       a7 = $urandom;
        default: a7 = {24'($urandom), 5'd0, 3'($urandom)};
      endcase
      if (a7[7:0] == 8'hFF && ($urandom % 2) == 0) a7[7:0] = 8'hFF;
      run_one(f, mk_ent(v, m, DESC_W'($urandom), EDATA_W'($urandom)), df, a0, a6, a7);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R11 watchdog expired: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule